// File: doc/BRIEF.md
# Masked-Write PHY Control Register Bank

This block holds the static and power-sequencing controls of a storage-card PHY in a small set of 32-bit registers. Each register stores 16 data bits. On a write, the upper half of the written word acts as a per-bit enable for the lower half. Software can therefore flip one field, such as the DLL enable, without first reading the register back. One extra word is read-only. It reports two completion flags that the PHY drives: calibration finished and DLL locked. The stored fields leave the block as separate decoded signals.

The host side is a plain single-cycle strobe port. A write takes effect at the clock edge where `wr_en` is sampled high. A read is requested with `rd_en`, and the data comes back one cycle later with `rvalid`. The port has no back-pressure: every strobe is accepted in the cycle it is presented. When a read and a write to the same word coincide, the read returns the value held before the write. Decoded field outputs follow the stored registers directly, so they change in the cycle after the accepting edge.

Top module: `phy_ctl_regbank`

## Requirements
- R1: On a write to a control word, stored data bit k (0..15) takes `wdata[k]` when `wdata[k+16]` is 1 and keeps its previous value when `wdata[k+16]` is 0.
- R2: A read strobe sampled at a clock edge produces `rvalid` high for exactly the following cycle. `rdata[31:16]` is then zero and `rdata[15:0]` is the addressed word's content at the strobe edge.
- R3: After reset every control word reads zero, except the word at offset 0x00, which reads 0x0200 (tap-delay select field = 4).
- R4: In the word at offset 0x18, bit 0 drives `pwr_up`, bit 1 drives `dll_en`, and bits 6:4 drive `drv_code` (0=50, 1=33, 2=66, 3=100, 4=40 ohm).
- R5: In the word at offset 0x00, bits 13:12 drive `freq_band` (0=200, 1=50, 2=100, 3=150 MHz band), bit 11 drives `tap_dly_en`, and bits 10:7 drive `tap_dly_sel`.
- R6: Bit 9 of the word at offset 0x08 drives `strobe_pd_en`.
- R7: A read of offset 0x20 returns `cal_done` in bit 6 and `dll_ready` in bit 5, sampled at the strobe edge. All other bits of that word are zero.
- R8: Writes to offset 0x20, to any offset above 0x18 other than 0x20, or to an offset that is not a multiple of 4 change no stored bit.
- R9: Reads of offsets other than the seven control words and the status word return zero.
- R10: Words at 0x04, 0x0C, 0x10 and 0x14 hold all 16 data bits as plain masked storage and read them back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| rd_en | input | 1 | Read strobe, one word per cycle |
| addr | input | 8 | Byte offset for read or write |
| wdata | input | 32 | Upper half: bit enables; lower half: data |
| rdata | output | 32 | Read data, valid while `rvalid` is high |
| rvalid | output | 1 | High for the cycle after an accepted read |
| cal_done | input | 1 | PHY calibration complete flag |
| dll_ready | input | 1 | PHY DLL lock flag |
| pwr_up | output | 1 | Analog power-up control (active high) |
| dll_en | output | 1 | DLL enable |
| drv_code | output | 3 | Output drive-strength code |
| freq_band | output | 2 | DLL frequency band select |
| tap_dly_en | output | 1 | Output tap-delay enable |
| tap_dly_sel | output | 4 | Output tap-delay select |
| strobe_pd_en | output | 1 | Strobe-line pull-down enable |

## Verification
Masked writes are driven with an all-enable mask, an empty mask, and alternating and single-bit masks over different data. Together these separate a correct per-bit merge from a plain overwrite, an ignored mask, or an inverted mask. The status flags are read in all four combinations, which exposes swapped or stuck bit positions. Writes to the status offset, to offsets past the bank and to misaligned offsets are each followed by a full readback and a check of every field output. These cases expose a decoder that aliases addresses or ignores the low address bits.

// File: rtl/phy_ctl_pkg.sv
package phy_ctl_pkg;
  localparam int DATA_W     = 16;
  localparam int BUS_W      = 2 * DATA_W;
  localparam int STATUS_OFS = 'h20;

  // Word indices of the decoded control words
  localparam int W_FREQ   = 0;
  localparam int W_STROBE = 2;
  localparam int W_POWER  = 6;

  // Field positions inside their words
  localparam int B_PWR      = 0;
  localparam int B_DLL      = 1;
  localparam int B_DRV_LSB  = 4;
  localparam int DRV_W      = 3;
  localparam int B_TAP_LSB  = 7;
  localparam int TAP_W      = 4;
  localparam int B_TAP_EN   = 11;
  localparam int B_FREQ_LSB = 12;
  localparam int FREQ_W     = 2;
  localparam int B_STROBE   = 9;
  localparam int B_ST_DLL   = 5;
  localparam int B_ST_CAL   = 6;

  function automatic logic [DATA_W-1:0] ctl_reset(input int idx, input int tap_rst);
    logic [DATA_W-1:0] v;
    v = '0;
    if (idx == W_FREQ) v[B_TAP_LSB +: TAP_W] = TAP_W'(tap_rst);
    return v;
  endfunction
endpackage

// File: rtl/phy_ctl_addr_dec.sv
module phy_ctl_addr_dec #(
  parameter int ADDR_W  = 8,
  parameter int NUM_CTL = 7,
  parameter int ST_OFS  = 'h20
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_CTL-1:0] ctl_hit,
  output logic               st_hit
);
  localparam int WORD_W = ADDR_W - 2;

  logic              aligned;
  logic [WORD_W-1:0] word;

  assign aligned = (addr[1:0] == 2'b00);
  assign word    = addr[ADDR_W-1:2];
  assign st_hit  = aligned && (word == WORD_W'(ST_OFS >> 2));

  for (genvar i = 0; i < NUM_CTL; i++) begin : g_hit
    assign ctl_hit[i] = aligned && (word == WORD_W'(i));
  end
endmodule

// File: rtl/phy_ctl_mask_reg.sv
module phy_ctl_mask_reg #(
  parameter int               W   = 16,
  parameter logic [W-1:0]     RST = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [2*W-1:0] din,
  output logic [W-1:0]   q
);
  logic [W-1:0] bit_en;
  logic [W-1:0] nxt;

  assign bit_en = din[2*W-1:W];
  assign nxt    = (q & ~bit_en) | (din[W-1:0] & bit_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST;
    else if (we) q <= nxt;
  end
endmodule

// File: rtl/phy_ctl_rd_mux.sv
module phy_ctl_rd_mux #(
  parameter int W       = 16,
  parameter int NUM_CTL = 7
) (
  input  logic [NUM_CTL-1:0][W-1:0] ctl_q,
  input  logic [NUM_CTL-1:0]        ctl_hit,
  input  logic                      st_hit,
  input  logic [W-1:0]              st_word,
  output logic [W-1:0]              rd_word
);
  always_comb begin
    rd_word = st_hit ? st_word : '0;
    for (int i = 0; i < NUM_CTL; i++) begin
      if (ctl_hit[i]) rd_word = rd_word | ctl_q[i];
    end
  end
endmodule

// File: rtl/phy_ctl_field_map.sv
module phy_ctl_field_map
  import phy_ctl_pkg::*;
(
  input  logic [DATA_W-1:0] freq_word,
  input  logic [DATA_W-1:0] strobe_word,
  input  logic [DATA_W-1:0] power_word,
  output logic              pwr_up,
  output logic              dll_en,
  output logic [DRV_W-1:0]  drv_code,
  output logic [FREQ_W-1:0] freq_band,
  output logic              tap_dly_en,
  output logic [TAP_W-1:0]  tap_dly_sel,
  output logic              strobe_pd_en
);
  assign pwr_up       = power_word[B_PWR];
  assign dll_en       = power_word[B_DLL];
  assign drv_code     = power_word[B_DRV_LSB +: DRV_W];
  assign freq_band    = freq_word[B_FREQ_LSB +: FREQ_W];
  assign tap_dly_en   = freq_word[B_TAP_EN];
  assign tap_dly_sel  = freq_word[B_TAP_LSB +: TAP_W];
  assign strobe_pd_en = strobe_word[B_STROBE];

  logic unused_field_bits;
  assign unused_field_bits = ^{freq_word, strobe_word, power_word};
endmodule

// File: rtl/phy_ctl_regbank.sv
module phy_ctl_regbank
  import phy_ctl_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NUM_CTL = 7,
  parameter int TAP_RST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  output logic              rvalid,
  input  logic              cal_done,
  input  logic              dll_ready,
  output logic              pwr_up,
  output logic              dll_en,
  output logic [DRV_W-1:0]  drv_code,
  output logic [FREQ_W-1:0] freq_band,
  output logic              tap_dly_en,
  output logic [TAP_W-1:0]  tap_dly_sel,
  output logic              strobe_pd_en
);
  logic [NUM_CTL-1:0]             ctl_hit;
  logic                           st_hit;
  logic [NUM_CTL-1:0][DATA_W-1:0] ctl_q;
  logic [DATA_W-1:0]              st_word;
  logic [DATA_W-1:0]              rd_word;

  phy_ctl_addr_dec #(
    .ADDR_W (ADDR_W),
    .NUM_CTL(NUM_CTL),
    .ST_OFS (STATUS_OFS)
  ) i_dec (
    .addr   (addr),
    .ctl_hit(ctl_hit),
    .st_hit (st_hit)
  );

  for (genvar i = 0; i < NUM_CTL; i++) begin : g_word
    phy_ctl_mask_reg #(
      .W  (DATA_W),
      .RST(ctl_reset(i, TAP_RST))
    ) i_reg (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (wr_en && ctl_hit[i]),
      .din  (wdata),
      .q    (ctl_q[i])
    );
  end

  always_comb begin
    st_word           = '0;
    st_word[B_ST_CAL] = cal_done;
    st_word[B_ST_DLL] = dll_ready;
  end

  phy_ctl_rd_mux #(
    .W      (DATA_W),
    .NUM_CTL(NUM_CTL)
  ) i_mux (
    .ctl_q  (ctl_q),
    .ctl_hit(ctl_hit),
    .st_hit (st_hit),
    .st_word(st_word),
    .rd_word(rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= {{(BUS_W-DATA_W){1'b0}}, rd_word};
    end
  end

  phy_ctl_field_map i_map (
    .freq_word   (ctl_q[W_FREQ]),
    .strobe_word (ctl_q[W_STROBE]),
    .power_word  (ctl_q[W_POWER]),
    .pwr_up      (pwr_up),
    .dll_en      (dll_en),
    .drv_code    (drv_code),
    .freq_band   (freq_band),
    .tap_dly_en  (tap_dly_en),
    .tap_dly_sel (tap_dly_sel),
    .strobe_pd_en(strobe_pd_en)
  );
endmodule

// File: rtl/phy_ctl_regbank_chk.sv
module phy_ctl_regbank_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic              rvalid,
  input logic              cal_done,
  input logic              dll_ready,
  input logic              pwr_up,
  input logic              dll_en
);
  localparam logic [ADDR_W-1:0] A_PWR = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] A_ST  = ADDR_W'('h20);

  AST_RVALID_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid); // R2
  AST_NO_STRAY_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid); // R2
  AST_UPPER_HALF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> (rdata[31:16] == 16'h0)); // R2
  AST_MASKED_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_PWR && wdata[16]) |=> (pwr_up == $past(wdata[0]))); // R1
  AST_MASKED_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_PWR && !wdata[17]) |=> $stable(dll_en)); // R1
  AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_ST) |=>
      (rdata == {25'h0, $past(cal_done), $past(dll_ready), 5'h0})); // R7
  AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_ST) |=> ($stable(pwr_up) && $stable(dll_en))); // R8
  AST_MISALIGNED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr[1:0] != 2'b00) |=> (rdata == 32'h0)); // R9
endmodule

bind phy_ctl_regbank phy_ctl_regbank_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .addr     (addr),
  .wdata    (wdata),
  .rdata    (rdata),
  .rvalid   (rvalid),
  .cal_done (cal_done),
  .dll_ready(dll_ready),
  .pwr_up   (pwr_up),
  .dll_en   (dll_en)
);

// File: tb/test_phy_ctl_regbank.sv
module test_phy_ctl_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic        cal_done = 1'b0;
  logic        dll_ready = 1'b0;
  logic        pwr_up, dll_en, tap_dly_en, strobe_pd_en;
  logic [2:0]  drv_code;
  logic [1:0]  freq_band;
  logic [3:0]  tap_dly_sel;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  logic [15:0] model [7];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #5 clk = ~clk;

  phy_ctl_regbank i_phy_ctl_regbank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .cal_done(cal_done),
    .dll_ready(dll_ready), .pwr_up(pwr_up), .dll_en(dll_en), .drv_code(drv_code),
    .freq_band(freq_band), .tap_dly_en(tap_dly_en), .tap_dly_sel(tap_dly_sel),
    .strobe_pd_en(strobe_pd_en)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard whenever read data comes back
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) check("R2 unexpected rvalid", 32'h1, 32'h0);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    if (a[1:0] == 2'b00 && a <= 8'h18) begin
      for (int k = 0; k < 16; k++)
        if (d[k+16]) model[a>>2][k] = d[k];
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_all(input string tag);
    for (int i = 0; i < 7; i++) rd(8'(i*4), {16'h0, model[i]}, tag);
  endtask

  task automatic chk_fields(input string tag);
    check({tag, " R4 pwr_up"},      32'(pwr_up),       32'(model[6][0]));
    check({tag, " R4 dll_en"},      32'(dll_en),       32'(model[6][1]));
    check({tag, " R4 drv_code"},    32'(drv_code),     32'(model[6][6:4]));
    check({tag, " R5 freq_band"},   32'(freq_band),    32'(model[0][13:12]));
    check({tag, " R5 tap_dly_en"},  32'(tap_dly_en),   32'(model[0][11]));
    check({tag, " R5 tap_dly_sel"}, 32'(tap_dly_sel),  32'(model[0][10:7]));
    check({tag, " R6 strobe_pd"},   32'(strobe_pd_en), 32'(model[2][9]));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 7; i++) model[i] = 16'h0;
    model[0] = 16'h0200;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R3 reset values
    chk_fields("R3 reset");
    rd_all("R3 reset readback");

    // R1 full mask, empty mask, alternating and single-bit masks
    wr(8'h04, 32'hFFFF_A5C3);
    rd(8'h04, 32'h0000_A5C3, "R1 full mask");
    wr(8'h04, 32'h0000_FFFF);
    rd(8'h04, 32'h0000_A5C3, "R1 empty mask");
    wr(8'h04, 32'h5555_FFFF);
    rd(8'h04, 32'h0000_F5D7, "R1 alternating mask");
    wr(8'h04, 32'h8000_0000);
    rd(8'h04, 32'h0000_75D7, "R1 single bit mask");

    // R10 plain storage words
    wr(8'h0C, 32'hFFFF_1234);
    wr(8'h10, 32'hFFFF_FEDC);
    wr(8'h14, 32'hF0F0_ABCD);
    rd(8'h0C, 32'h0000_1234, "R10 word 0x0C");
    rd(8'h10, 32'h0000_FEDC, "R10 word 0x10");
    rd(8'h14, 32'h0000_A0C0, "R10 word 0x14");

    // R4 power word fields, set one at a time
    wr(8'h18, 32'h0001_0001);
    chk_fields("R4 pwr only");
    wr(8'h18, 32'h0072_0042);
    chk_fields("R4 dll+drv");
    wr(8'h18, 32'h0001_0000);
    chk_fields("R4 pwr off keep dll");

    // R5 frequency word fields, tap select kept when unmasked
    wr(8'h00, 32'h3800_2800);
    chk_fields("R5 band+en");
    wr(8'h00, 32'h0780_0780);
    chk_fields("R5 tap sel");
    rd(8'h00, {16'h0, model[0]}, "R5 readback");

    // R6 strobe pull-down
    wr(8'h08, 32'h0200_0200);
    chk_fields("R6 set");
    wr(8'h08, 32'hFDFF_0000);
    chk_fields("R6 others cleared, pd kept");

    // R7 status combos
    for (int s = 0; s < 4; s++) begin
      cal_done = s[1]; dll_ready = s[0];
      rd(8'h20, {25'h0, s[1], s[0], 5'h0}, "R7 status");
    end

    // R8 ignored writes
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h1C, 32'hFFFF_0000);
    wr(8'h24, 32'hFFFF_0000);
    wr(8'h19, 32'hFFFF_0000);
    wr(8'h02, 32'hFFFF_0000);
    wr(8'h40, 32'hFFFF_0000);
    chk_fields("R8 after ignored writes");
    rd_all("R8 readback after ignored writes");

    // R9 unmapped reads
    rd(8'h1C, 32'h0, "R9 offset 0x1C");
    rd(8'h24, 32'h0, "R9 offset 0x24");
    rd(8'h01, 32'h0, "R9 offset 0x01");
    rd(8'h22, 32'h0, "R9 offset 0x22");
    rd(8'hFC, 32'h0, "R9 offset 0xFC");

    repeat (3) @(negedge clk);
    check("R2 scoreboard drained", 32'(exp_q.size()), 32'h0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule